// File: doc/BRIEF.md
# Shift-Add Dual-Microphone Spectral Masker

This block suppresses low-quality time-frequency content in a two-microphone speech front end. It takes one frequency bin per beat from each channel, in polar form: the magnitude and phase of both channels, the bin number and a delay estimate for the talker of interest. From these it forms the inter-channel phase error that remains after the expected delay has been removed. It wraps the error, takes its magnitude and quantizes it into steps of about 0.05 rad. The step index selects a gain code from a table that is built at elaboration.

The gain code attenuates each channel's magnitude using only a barrel right shift plus up to three further shifted copies, summed. The two masked magnitudes are then averaged into one beamformed magnitude. No multiplier or divider sits in the masking path. The table approximates the curve 1/(1+γθ²), with γ set by a parameter (default 5).

Bins enter and leave on valid/ready streams. Every stage stalls together when the output is held, so the latency is a fixed number of cycles.

Top module: `dual_mic_phase_masker`

## Requirements
- R1: During and after reset, with no beat accepted yet, out_valid_o is 0 and in_ready_o is 1.
- R2: The phase error, in units where 65536 is one full turn, is θ = (ph1 − ph2 − 8·d·k) mod 65536. Here k is the unsigned bin number and d is the signed delay in eighths of a sample, for a 1024-point transform.
- R3: θ is read as a 16-bit two's-complement value, which wraps it into [−π, π). Its magnitude |θ| is used, and 0x8000 maps to 32768.
- R4: The step index is min((|θ|·126) >> 16, 62), so any error above the top step uses the last of the 63 entries.
- R5: Table entry i has den = 1600 + GAMMA·(2i+1)². Its shift p1 is the smallest value in 0..15 with 1600·2^p1 ≥ den, or 15 if there is none. Its 3-bit fraction f is floor(1600·2^p1·8/den) − 8, clamped to 0..7. The code is {p1[3:0], f[2:0]}, and f[2], f[1] and f[0] enable the halves, quarters and eighths terms.
- R6: A masked magnitude is (M>>p1) + f[2]·(M>>(p1+1)) + f[1]·(M>>(p1+2)) + f[0]·(M>>(p1+3)). Each term is truncated separately, and the result never exceeds 2·M.
- R7: out_mag_o = (S1 + S2) >> 1, where S1 and S2 are the two masked magnitudes. The sum is formed one bit wider than the operands, so it never overflows.
- R8: A beat accepted at a rising edge, with out_ready_i high, appears on out_valid_o/out_mag_o right after the fourth rising edge, counting the accepting edge. Beats come out in order, one per cycle when streaming.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_mag_o holds stable, the whole pipeline stalls and in_ready_o is 0. No beat is lost or duplicated.
- R10: Two bins whose phase errors are +θ and −θ, with equal magnitudes, give the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input bin valid |
| in_ready_o | output | 1 | Block can accept a bin |
| in_ph1_i | input | 16 | Channel 1 phase, 65536 = one turn |
| in_ph2_i | input | 16 | Channel 2 phase, 65536 = one turn |
| in_mag1_i | input | 16 | Channel 1 magnitude |
| in_mag2_i | input | 16 | Channel 2 magnitude |
| in_bin_i | input | 9 | Bin number k |
| in_delay_i | input | 10 | Signed delay estimate, eighths of a sample |
| out_valid_o | output | 1 | Output magnitude valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_mag_o | output | 17 | Beamformed masked magnitude |

## Verification
Each result is due at a fixed point. A single bin fed with the output ready must show out_valid_o low after the second and third rising edges and high, with its value, after the fourth. The bench drives and samples on falling edges and counts edges from the accepting one, so every compare lands in the one cycle where the value is due. Streaming checks expect bin j exactly four samples after it was driven. The stall scenario takes its samples only after the pipeline has filled, and then checks the held value and in_ready_o on each cycle until release.

// File: rtl/phase_mask_pkg.sv
package phase_mask_pkg;
    parameter int PH_W   = 16;
    parameter int MAG_W  = 16;
    parameter int BIN_W  = 9;
    parameter int DLY_W  = 10;
    parameter int NSTEPS = 63;
    parameter int SH_W   = 4;
    parameter int FR_W   = 3;

    localparam int IDX_W  = $clog2(NSTEPS);
    localparam int CODE_W = SH_W + FR_W;
    localparam int OUT_W  = MAG_W + 1;

    typedef logic [1:0][MAG_W-1:0] mag_pair_t;

    typedef struct packed {
        logic             vld;
        logic [PH_W-1:0]  dph;
        logic [PH_W-1:0]  dterm;
        mag_pair_t        mag;
    } st1_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        mag_pair_t        mag;
    } st2_t;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        mag_pair_t         mag;
    } st3_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] res;
    } st4_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
        st4_t s4;
    } pipe_t;
endpackage

// File: rtl/phase_err_quant.sv
module phase_err_quant
    import phase_mask_pkg::*;
#(
    parameter int STEP_RECIP = 126
) (
    input  logic [PH_W-1:0]  dph_i,
    input  logic [PH_W-1:0]  dterm_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam int RW = $clog2(STEP_RECIP + 1);

    logic [PH_W-1:0]    theta;
    logic [PH_W-1:0]    mag;
    logic [PH_W+RW-1:0] prod;
    logic [RW-1:0]      raw;

    always_comb begin
        theta = dph_i - dterm_i;
        // two's-complement read wraps to [-pi, pi); magnitude of 0x8000 stays 0x8000
        mag   = theta[PH_W-1] ? (~theta + 1'b1) : theta;
        prod  = (PH_W+RW)'(mag) * (PH_W+RW)'(STEP_RECIP);
        raw   = prod[PH_W+RW-1:PH_W];
        idx_o = (raw > RW'(NSTEPS - 1)) ? IDX_W'(NSTEPS - 1) : raw[IDX_W-1:0];
    end
endmodule

// File: rtl/mask_step_rom.sv
module mask_step_rom
    import phase_mask_pkg::*;
#(
    parameter int GAMMA = 5
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o
);
    function automatic logic [CODE_W-1:0] step_code(input int i);
        longint den;
        longint num;
        longint q;
        int     sh;
        logic   hit;
        den = 64'd1600 + longint'(GAMMA) * longint'((2*i+1) * (2*i+1));
        sh  = (1 << SH_W) - 1;
        hit = 1'b0;
        for (int p = 0; p < (1 << SH_W); p++) begin
            if (!hit && ((64'd1600 << p) >= den)) begin
                sh  = p;
                hit = 1'b1;
            end
        end
        num = (64'd1600 << sh) * 8;
        q   = num / den - 8;
        if (q < 0) q = 0;
        if (q > 7) q = 7;
        return {SH_W'(sh), FR_W'(q)};
    endfunction

    logic [CODE_W-1:0] tbl [NSTEPS];

    for (genvar g = 0; g < NSTEPS; g++) begin : g_entry
        assign tbl[g] = step_code(g);
    end

    always_comb begin
        if (int'(idx_i) < NSTEPS) code_o = tbl[idx_i];
        else                      code_o = tbl[NSTEPS-1];
    end
endmodule

// File: rtl/shift_add_scaler.sv
module shift_add_scaler
    import phase_mask_pkg::*;
(
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [OUT_W-1:0]  scaled_o
);
    logic [SH_W:0]    base;
    logic [FR_W-1:0]  frac;
    logic [OUT_W-1:0] t0, t1, t2, t3;

    always_comb begin
        base = {1'b0, code_i[CODE_W-1:FR_W]};
        frac = code_i[FR_W-1:0];
        t0 = OUT_W'(mag_i >> base);
        t1 = frac[2] ? OUT_W'(mag_i >> (base + 1'b1))   : '0;
        t2 = frac[1] ? OUT_W'(mag_i >> (base + 2'd2))   : '0;
        t3 = frac[0] ? OUT_W'(mag_i >> (base + 2'd3))   : '0;
        scaled_o = t0 + t1 + t2 + t3;
    end
endmodule

// File: rtl/dual_mic_phase_masker.sv
module dual_mic_phase_masker
    import phase_mask_pkg::*;
#(
    parameter int GAMMA      = 5,
    parameter int STEP_RECIP = 126,
    parameter int FFT_N      = 1024,
    parameter int DLY_FRAC   = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    in_valid_i,
    output logic                    in_ready_o,
    input  logic [PH_W-1:0]         in_ph1_i,
    input  logic [PH_W-1:0]         in_ph2_i,
    input  logic [MAG_W-1:0]        in_mag1_i,
    input  logic [MAG_W-1:0]        in_mag2_i,
    input  logic [BIN_W-1:0]        in_bin_i,
    input  logic signed [DLY_W-1:0] in_delay_i,
    output logic                    out_valid_o,
    input  logic                    out_ready_i,
    output logic [OUT_W-1:0]        out_mag_o
);
    localparam int DT_SHIFT = PH_W - $clog2(FFT_N) - DLY_FRAC;
    localparam int PROD_W   = DLY_W + BIN_W + 1;

    pipe_t pipe_d, pipe_q;

    logic                     adv;
    logic signed [PROD_W-1:0] dk_prod;
    logic [IDX_W-1:0]         idx_w;
    logic [CODE_W-1:0]        code_w;
    logic [1:0][OUT_W-1:0]    scaled_w;
    logic [OUT_W:0]           sum_w;

    phase_err_quant #(.STEP_RECIP(STEP_RECIP)) u_quant (
        .dph_i   (pipe_q.s1.dph),
        .dterm_i (pipe_q.s1.dterm),
        .idx_o   (idx_w)
    );

    mask_step_rom #(.GAMMA(GAMMA)) u_rom (
        .idx_i  (pipe_q.s2.idx),
        .code_o (code_w)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        shift_add_scaler u_scale (
            .mag_i    (pipe_q.s3.mag[ch]),
            .code_i   (pipe_q.s3.code),
            .scaled_o (scaled_w[ch])
        );
    end

    always_comb begin
        adv     = !pipe_q.s4.vld || out_ready_i;
        dk_prod = PROD_W'(in_delay_i) * $signed({1'b0, in_bin_i});
        sum_w   = (OUT_W+1)'(scaled_w[0]) + (OUT_W+1)'(scaled_w[1]);
        pipe_d  = pipe_q;
        if (adv) begin
            pipe_d.s1.vld    = in_valid_i;
            pipe_d.s1.dph    = in_ph1_i - in_ph2_i;
            pipe_d.s1.dterm  = PH_W'(dk_prod) << DT_SHIFT;
            pipe_d.s1.mag[0] = in_mag1_i;
            pipe_d.s1.mag[1] = in_mag2_i;

            pipe_d.s2.vld    = pipe_q.s1.vld;
            pipe_d.s2.idx    = idx_w;
            pipe_d.s2.mag    = pipe_q.s1.mag;

            pipe_d.s3.vld    = pipe_q.s2.vld;
            pipe_d.s3.code   = code_w;
            pipe_d.s3.mag    = pipe_q.s2.mag;

            pipe_d.s4.vld    = pipe_q.s3.vld;
            pipe_d.s4.res    = sum_w[OUT_W:1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= pipe_d;
    end

    assign in_ready_o  = adv;
    assign out_valid_o = pipe_q.s4.vld;
    assign out_mag_o   = pipe_q.s4.res;

    AST_READY_RULE: assert property (@(posedge clk_i) disable iff (rst_i)
        !out_valid_o |-> in_ready_o);                                        // R9
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_mag_o))); // R9
    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        pipe_q.s1.vld |-> (int'(idx_w) < NSTEPS));                           // R4
    AST_SCALE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        pipe_q.s3.vld |-> (scaled_w[0] <= {pipe_q.s3.mag[0], 1'b0}));        // R6
endmodule

// File: tb/dual_mic_phase_masker_bench.sv
module dual_mic_phase_masker_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [15:0]        ph1 = '0, ph2 = '0, m1 = '0, m2 = '0;
    logic [8:0]         bin = '0;
    logic signed [9:0]  dly = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [16:0]        out_mag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dual_mic_phase_masker u_dual_mic_phase_masker (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_ph1_i(ph1), .in_ph2_i(ph2), .in_mag1_i(m1), .in_mag2_i(m2),
        .in_bin_i(bin), .in_delay_i(dly), .out_valid_o(out_valid),
        .out_ready_i(out_ready), .out_mag_o(out_mag)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 act %0d exp %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int entry_code(input int i);
        longint den = 1600 + 5 * (2*i+1) * (2*i+1);
        int p = 15;
        longint f;
        for (int s = 15; s >= 0; s--) if ((64'd1600 << s) >= den) p = s;
        f = ((64'd1600 << p) * 8) / den - 8;
        if (f < 0) f = 0;
        if (f > 7) f = 7;
        return p * 8 + int'(f);
    endfunction

    function automatic int scale(input int m, input int code);
        int p = code / 8;
        int f = code % 8;
        int s = m >> p;
        if (f & 4) s += m >> (p + 1);
        if (f & 2) s += m >> (p + 2);
        if (f & 1) s += m >> (p + 3);
        return s;
    endfunction

    function automatic int model(input int a1, input int a2, input int k, input int d,
                                 input int g1, input int g2);
        int t = (a1 - a2 - d * k * 8) & 32'hFFFF;
        int mag;
        int idx;
        int c;
        if (t >= 32768) t -= 65536;
        mag = (t < 0) ? -t : t;
        idx = (mag * 126) >>> 16;
        if (idx > 62) idx = 62;
        c = entry_code(idx);
        return (scale(g1, c) + scale(g2, c)) >> 1;
    endfunction

    task automatic drive(input int a1, input int a2, input int k, input int d,
                         input int g1, input int g2);
        in_valid = 1'b1;
        ph1 = 16'(a1); ph2 = 16'(a2); bin = 9'(k); dly = 10'(d);
        m1 = 16'(g1); m2 = 16'(g2);
    endtask

    // single beat, output ready, latency checked edge by edge
    task automatic send_one(input int a1, input int a2, input int k, input int d,
                            input int g1, input int g2, input string req, output int got);
        int exp = model(a1, a2, k, d, g1, g2);
        @(negedge clk);
        drive(a1, a2, k, d, g1, g2);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid, "R8 early after edge 2", out_valid, 0);
        @(negedge clk);
        check(!out_valid, "R8 early after edge 3", out_valid, 0);
        @(negedge clk);
        check(out_valid, "R8 due after edge 4", out_valid, 1);
        check(out_mag == 17'(exp), req, out_mag, exp);
        got = int'(out_mag);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!out_valid, "R1 valid in reset", out_valid, 0);
        check(in_ready, "R1 ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1 valid after reset", out_valid, 0);
        check(in_ready, "R1 ready after reset", in_ready, 1);
    endtask

    task automatic t_basic();
        int r;
        send_one(1000, 1000, 0, 0, 40000, 20000, "R6 R7 zero error, all flags set", r);
        check(r == 28125, "R5 R6 R7 zero-error literal", r, 28125);
        send_one(5000, 0, 100, 6, 30000, 12345, "R2 delay term cancels error", r);
        send_one(3000, 0, 0, 0, 50000, 50000, "R5 mid step", r);
        send_one(9000, 0, 0, 0, 777, 60000, "R5 R6 deep step", r);
        send_one(65535, 65535, 0, 0, 65535, 65535, "R7 no overflow at full scale", r);
    endtask

    task automatic t_wrap_sym();
        int rp, rn;
        send_one(100, 65000, 0, 0, 20000, 10000, "R3 wrap positive", rp);
        send_one(65000, 100, 0, 0, 20000, 10000, "R3 wrap negative", rn);
        check(rp == rn, "R10 symmetric error", rn, rp);
        send_one(32768, 0, 0, 0, 60000, 60000, "R4 clamp at pi", rp);
        send_one(20000, 0, 511, -20, 45000, 3000, "R2 negative delay, top bin", rp);
    endtask

    task automatic t_stream();
        int exp [8];
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (t >= 4) begin
                check(out_valid, "R8 stream valid", out_valid, 1);
                check(out_mag == 17'(exp[t-4]), "R8 stream order", out_mag, exp[t-4]);
            end
            if (t < 8) begin
                exp[t] = model(t * 4100, 300, t * 37, t - 3, 9000 + t * 5000, 61000 - t * 7000);
                drive(t * 4100, 300, t * 37, t - 3, 9000 + t * 5000, 61000 - t * 7000);
            end else in_valid = 1'b0;
        end
        @(negedge clk);
        check(!out_valid, "R8 stream drained", out_valid, 0);
    endtask

    task automatic t_stall();
        int exp [6];
        int sent = 0;
        int got = 0;
        for (int b = 0; b < 6; b++) exp[b] = model(b * 2900, 0, 0, 0, 30000 + b, 8000 * b);
        out_ready = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (sent < 6) drive(sent * 2900, 0, 0, 0, 30000 + sent, 8000 * sent);
            else in_valid = 1'b0;
            #1;
            if (c >= 6) begin
                check(out_valid, "R9 held valid", out_valid, 1);
                check(out_mag == 17'(exp[0]), "R9 held value", out_mag, exp[0]);
                check(!in_ready, "R9 ready low in stall", in_ready, 0);
            end
            if (in_valid && in_ready) sent++;
        end
        check(sent == 4, "R9 beats taken while stalled", sent, 4);
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (sent < 6) drive(sent * 2900, 0, 0, 0, 30000 + sent, 8000 * sent);
            else in_valid = 1'b0;
            #1;
            if (in_valid && in_ready) sent++;
            if (out_valid && out_ready) begin
                if (got < 6) check(out_mag == 17'(exp[got]), "R9 order after release", out_mag, exp[got]);
                got++;
            end
        end
        check(got == 6, "R9 no loss or duplicate", got, 6);
        check(!out_valid, "R9 drained", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap_sym();
        t_stream();
        t_stall();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule